// File: doc/BRIEF.md
# PCI Scatter-Gather Window Translator

This block turns a 32-bit PCI bus address into a 34-bit system DMA address. Four programmable windows decide how each address is handled. Each window owns three 64-bit registers: a window base (enable flag, scatter-gather flag and compare field), a window mask (size of the window) and a translated base. These registers sit in a small CSR bank together with a control register and three fixed-value registers. Software reaches them through a single-cycle request port with a registered response.

A translation request is accepted with a valid/ready handshake. The address is compared against all windows in the same cycle, and the lowest-numbered matching window wins. A direct-mapped window produces its result at once from the translated base and the in-window offset. A scatter-gather window first builds the address of a 64-bit page-table entry and fetches that entry through a request/response memory port. The DMA address is then assembled from the returned page frame and the page offset. An address that matches no window returns a miss. In every case the result is held until the consumer accepts it.

The sequencer has four states:
- `ST_IDLE`: ready for a request.
- `ST_FETCH`: the entry read is offered to memory.
- `ST_WAIT`: waiting for the memory response.
- `ST_HOLD`: the result is presented.

The transitions are:
- `ST_IDLE` to `ST_FETCH` on a scatter-gather hit.
- `ST_IDLE` to `ST_HOLD` on a direct hit or a miss.
- `ST_FETCH` to `ST_WAIT` when memory takes the request.
- `ST_WAIT` to `ST_HOLD` when the response arrives.
- `ST_HOLD` to `ST_IDLE` when the result is accepted.

Top module: `pci_sg_translator`

## Requirements
- R1: CSR index map. Indices 0-3 are the window bases of windows 0-3, 4-7 the window masks, 8-11 the translated bases, and 12 the control register. A write with size code 3 stores all 64 bits, and a later read returns them one cycle after the request.
- R2: After reset, the control register reads 64'h0000_0021_0010_0000 (bit 20 and bit 32 set, value 2 in the field at bit 36). All window, mask and translated-base registers read zero. After reset `tr_ready` is 1 and `res_valid` and `mem_req_valid` are 0.
- R3: Indices 13 (error), 14 (error mask) and 15 (invalidate-all) always read zero. Writes to them change no register and no translation result.
- R4: Only size code 3 (eight bytes) is accepted; codes 0, 1 and 2 are rejected. A rejected access sets `csr_rej` in the response cycle, returns zero data and writes nothing.
- R5: Window w matches when base[0] is 1 and (bus[31:20] & ~mask[31:20]) equals base[31:20]. When several windows match, the lowest index is used. A window with base[0] = 0 never matches.
- R6: A hit on a window with base[1] = 0 (direct) gives translated_base | (bus & {mask[31:20], 20'hFFFFF}), with no memory read.
- R7: A hit on a window with base[1] = 1 (scatter-gather) issues exactly one memory read. The read address is (translated_base & ~((M >> 10) | 7)) | ((bus & M) >> 10), where M = {mask[31:20], 20'h0} | 32'h000F_E000.
- R8: The scatter-gather result is ((entry & ~1) << 12) | bus[12:0], where entry is the returned 64-bit word.
- R9: Every DMA address and entry address is cut to 34 bits (mask 0x3_FFFF_FFFF). Translated-base bits above bit 33 never reach an output.
- R10: When no window matches, `res_miss` is 1, `res_addr` is zero and no memory read is made.
- R11: A result stays valid and unchanged while `res_ready` is low, and `tr_ready` stays low until the result is taken. A memory request stays valid with a stable address while `mem_req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | CSR access strobe, one cycle |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_idx | input | 4 | Register index |
| csr_size | input | 2 | Access size code, 3 = eight bytes |
| csr_wdata | input | 64 | Write data |
| csr_ack | output | 1 | Response cycle of an access |
| csr_rej | output | 1 | Access refused for its size |
| csr_rdata | output | 64 | Read data, valid with csr_ack |
| tr_valid | input | 1 | Translation request valid |
| tr_ready | output | 1 | Translator can take a request |
| tr_addr | input | 32 | PCI bus address to translate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_addr | output | 34 | Translated DMA address |
| res_miss | output | 1 | No window matched |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_addr | output | 34 | Entry address |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 64 | Returned page-table entry |

## Verification
The windows are programmed as one small direct window whose translated base has bits above bit 33, a mid-sized scatter-gather window, and two overlapping large windows (direct below, scatter-gather above). A single address set can then tell direct from scatter-gather arithmetic, lowest-index priority from an overlap, and a true miss from a hit. The addresses include window edges, all-ones and all-zero offsets, and entries whose page frame overflows 34 bits. Each of these shows a different error in masking, shifting or truncation. Memory stalls and response latencies vary across the list, and one result is held under backpressure to separate handshake faults from arithmetic ones. Disabling windows afterwards checks that the enable flag, and not a stale match, decides the route.

// File: rtl/pst_pkg.sv
package pst_pkg;

    localparam int PST_NUM_WIN   = 4;
    localparam int PST_BUS_AW    = 32;
    localparam int PST_DMA_AW    = 34;
    localparam int PST_DW        = 64;
    localparam int PST_WIN_LSB   = 20;
    localparam int PST_PAGE_LSB  = 13;
    localparam int PST_PTE_SHIFT = 10;
    localparam int PST_PFN_SHIFT = 12;

    localparam logic [1:0]  SIZE_DWORD = 2'd3;
    localparam logic [63:0] CTRL_RST   = 64'h0000_0021_0010_0000;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2,
        ST_HOLD  = 2'd3
    } pst_state_e;

endpackage

// File: rtl/pst_csr_bank.sv
module pst_csr_bank
    import pst_pkg::*;
#(
    parameter int NUM_WIN = PST_NUM_WIN,
    parameter int DW      = PST_DW,
    localparam int NREG   = 3 * NUM_WIN + 4,
    localparam int IW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csr_req,
    input  logic          csr_we,
    input  logic [IW-1:0] csr_idx,
    input  logic [1:0]    csr_size,
    input  logic [DW-1:0] csr_wdata,
    output logic          csr_ack,
    output logic          csr_rej,
    output logic [DW-1:0] csr_rdata,
    output logic [DW-1:0] base_o [NUM_WIN],
    output logic [DW-1:0] mask_o [NUM_WIN],
    output logic [DW-1:0] xl_o   [NUM_WIN]
);

    localparam int IDX_CTRL  = 3 * NUM_WIN;
    localparam int IDX_ERR   = IDX_CTRL + 1;

    logic          size_ok;
    logic          wr_ok;
    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] rd_mux;

    assign size_ok = (csr_size == SIZE_DWORD);
    assign wr_ok   = csr_req && csr_we && size_ok;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_regs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[w] <= '0;
                mask_o[w] <= '0;
                xl_o[w]   <= '0;
            end else if (wr_ok) begin
                if (csr_idx == IW'(w))
                    base_o[w] <= csr_wdata;
                if (csr_idx == IW'(NUM_WIN + w))
                    mask_o[w] <= csr_wdata;
                if (csr_idx == IW'(2 * NUM_WIN + w))
                    xl_o[w] <= csr_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= DW'(CTRL_RST);
        else if (wr_ok && csr_idx == IW'(IDX_CTRL))
            ctrl_q <= csr_wdata;
    end

    // Error, error-mask and invalidate-all indices fall through to zero.
    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (csr_idx == IW'(w))
                rd_mux = base_o[w];
            if (csr_idx == IW'(NUM_WIN + w))
                rd_mux = mask_o[w];
            if (csr_idx == IW'(2 * NUM_WIN + w))
                rd_mux = xl_o[w];
        end
        if (csr_idx == IW'(IDX_CTRL))
            rd_mux = ctrl_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_ack   <= 1'b0;
            csr_rej   <= 1'b0;
            csr_rdata <= '0;
        end else begin
            csr_ack   <= csr_req;
            csr_rej   <= csr_req && !size_ok;
            csr_rdata <= (csr_req && size_ok && !csr_we) ? rd_mux : '0;
        end
    end

    // R4
    size_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && csr_size != SIZE_DWORD) |=> (csr_rej && csr_rdata == '0));

    // R3
    fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_we && csr_idx >= IW'(IDX_ERR)) |=> (csr_rdata == '0));

endmodule

// File: rtl/pst_win_match.sv
module pst_win_match
    import pst_pkg::*;
#(
    parameter int NUM_WIN   = PST_NUM_WIN,
    parameter int BUS_AW    = PST_BUS_AW,
    parameter int DMA_AW    = PST_DMA_AW,
    parameter int DW        = PST_DW,
    parameter int WIN_LSB   = PST_WIN_LSB,
    parameter int PAGE_LSB  = PST_PAGE_LSB,
    parameter int PTE_SHIFT = PST_PTE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     base_i [NUM_WIN],
    input  logic [DW-1:0]     mask_i [NUM_WIN],
    input  logic [DW-1:0]     xl_i   [NUM_WIN],
    output logic              hit_o,
    output logic              sg_o,
    output logic [DMA_AW-1:0] pte_o,
    output logic [DMA_AW-1:0] direct_o
);

    localparam int FW = BUS_AW - WIN_LSB;
    localparam int WW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam logic [DW-1:0] PG_MASK =
        ((DW'(1) << WIN_LSB) - DW'(1)) & ~((DW'(1) << PAGE_LSB) - DW'(1));

    logic [NUM_WIN-1:0] hit_vec;
    logic [NUM_WIN-1:0] sg_vec;
    logic [FW-1:0]      fmsk     [NUM_WIN];
    logic [DW-1:0]      ba_mask  [NUM_WIN];
    logic [DW-1:0]      pte_full [NUM_WIN];
    logic [DW-1:0]      dir_full [NUM_WIN];
    logic [NUM_WIN-1:0] bits_unused;
    logic [WW-1:0]      sel;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign fmsk[w]    = mask_i[w][BUS_AW-1:WIN_LSB];
        assign hit_vec[w] = base_i[w][0] &&
            ((bus_addr[BUS_AW-1:WIN_LSB] & ~fmsk[w]) == base_i[w][BUS_AW-1:WIN_LSB]);
        assign sg_vec[w]  = base_i[w][1];
        assign ba_mask[w] = DW'({fmsk[w], {WIN_LSB{1'b0}}}) | PG_MASK;
        assign pte_full[w] =
            (xl_i[w] & ~((ba_mask[w] >> PTE_SHIFT) | DW'(7))) |
            ((DW'(bus_addr) & ba_mask[w]) >> PTE_SHIFT);
        assign dir_full[w] =
            xl_i[w] | DW'(bus_addr & {fmsk[w], {WIN_LSB{1'b1}}});
        assign bits_unused[w] = ^{base_i[w][DW-1:BUS_AW], base_i[w][WIN_LSB-1:2],
                                  mask_i[w][DW-1:BUS_AW], mask_i[w][WIN_LSB-1:0],
                                  pte_full[w][DW-1:DMA_AW], dir_full[w][DW-1:DMA_AW]};
    end

    // Lowest index wins: scan downward so the last assignment is the lowest hit.
    always_comb begin
        sel = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w])
                sel = WW'(w);
        end
    end

    assign hit_o    = |hit_vec;
    assign sg_o     = sg_vec[sel];
    assign pte_o    = pte_full[sel][DMA_AW-1:0];
    assign direct_o = dir_full[sel][DMA_AW-1:0];

    // R5
    prio_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> (hit_vec[sel] &&
                   ((hit_vec & ((NUM_WIN'(1) << sel) - NUM_WIN'(1))) == '0)));

endmodule

// File: rtl/pst_seq.sv
module pst_seq
    import pst_pkg::*;
#(
    parameter int DMA_AW    = PST_DMA_AW,
    parameter int DW        = PST_DW,
    parameter int PAGE_LSB  = PST_PAGE_LSB,
    parameter int PFN_SHIFT = PST_PFN_SHIFT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tr_valid,
    output logic                tr_ready,
    input  logic [PAGE_LSB-1:0] tr_off,
    input  logic                m_hit,
    input  logic                m_sg,
    input  logic [DMA_AW-1:0]   m_pte,
    input  logic [DMA_AW-1:0]   m_direct,
    output logic                res_valid,
    input  logic                res_ready,
    output logic [DMA_AW-1:0]   res_addr,
    output logic                res_miss,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [DMA_AW-1:0]   mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [DW-1:0]       mem_rsp_data
);

    pst_state_e          state_q, state_d;
    logic [DMA_AW-1:0]   pte_q;
    logic [PAGE_LSB-1:0] off_q;
    logic [DMA_AW-1:0]   res_q;
    logic                miss_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d       = state_q;
        tr_ready      = 1'b0;
        mem_req_valid = 1'b0;
        res_valid     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                tr_ready = 1'b1;
                if (tr_valid)
                    state_d = (m_hit && m_sg) ? ST_FETCH : ST_HOLD;
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready)
                    state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid)
                    state_d = ST_HOLD;
            end
            ST_HOLD: begin
                res_valid = 1'b1;
                if (res_ready)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_q  <= '0;
            off_q  <= '0;
            res_q  <= '0;
            miss_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && tr_valid) begin
                pte_q  <= m_pte;
                off_q  <= tr_off;
                res_q  <= m_hit ? m_direct : '0;
                miss_q <= !m_hit;
            end
            if (state_q == ST_WAIT && mem_rsp_valid) begin
                res_q  <= DMA_AW'({mem_rsp_data[DW-1:1], 1'b0} << PFN_SHIFT) |
                          DMA_AW'(off_q);
                miss_q <= 1'b0;
            end
        end
    end

    assign mem_req_addr = pte_q;
    assign res_addr     = res_q;
    assign res_miss     = miss_q;

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=>
            (res_valid && $stable(res_addr) && $stable(res_miss)));

    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R10
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_miss) |-> (res_addr == '0));

endmodule

// File: rtl/pci_sg_translator.sv
module pci_sg_translator
    import pst_pkg::*;
#(
    parameter int NUM_WIN = PST_NUM_WIN,
    parameter int BUS_AW  = PST_BUS_AW,
    parameter int DMA_AW  = PST_DMA_AW,
    parameter int DW      = PST_DW
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             csr_req,
    input  logic                             csr_we,
    input  logic [$clog2(3*NUM_WIN+4)-1:0]   csr_idx,
    input  logic [1:0]                       csr_size,
    input  logic [DW-1:0]                    csr_wdata,
    output logic                             csr_ack,
    output logic                             csr_rej,
    output logic [DW-1:0]                    csr_rdata,
    input  logic                             tr_valid,
    output logic                             tr_ready,
    input  logic [BUS_AW-1:0]                tr_addr,
    output logic                             res_valid,
    input  logic                             res_ready,
    output logic [DMA_AW-1:0]                res_addr,
    output logic                             res_miss,
    output logic                             mem_req_valid,
    input  logic                             mem_req_ready,
    output logic [DMA_AW-1:0]                mem_req_addr,
    input  logic                             mem_rsp_valid,
    input  logic [DW-1:0]                    mem_rsp_data
);

    logic [DW-1:0]     base_w [NUM_WIN];
    logic [DW-1:0]     mask_w [NUM_WIN];
    logic [DW-1:0]     xl_w   [NUM_WIN];
    logic              m_hit;
    logic              m_sg;
    logic [DMA_AW-1:0] m_pte;
    logic [DMA_AW-1:0] m_direct;

    pst_csr_bank #(
        .NUM_WIN (NUM_WIN),
        .DW      (DW)
    ) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_req   (csr_req),
        .csr_we    (csr_we),
        .csr_idx   (csr_idx),
        .csr_size  (csr_size),
        .csr_wdata (csr_wdata),
        .csr_ack   (csr_ack),
        .csr_rej   (csr_rej),
        .csr_rdata (csr_rdata),
        .base_o    (base_w),
        .mask_o    (mask_w),
        .xl_o      (xl_w)
    );

    pst_win_match #(
        .NUM_WIN   (NUM_WIN),
        .BUS_AW    (BUS_AW),
        .DMA_AW    (DMA_AW),
        .DW        (DW),
        .WIN_LSB   (PST_WIN_LSB),
        .PAGE_LSB  (PST_PAGE_LSB),
        .PTE_SHIFT (PST_PTE_SHIFT)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (tr_addr),
        .base_i   (base_w),
        .mask_i   (mask_w),
        .xl_i     (xl_w),
        .hit_o    (m_hit),
        .sg_o     (m_sg),
        .pte_o    (m_pte),
        .direct_o (m_direct)
    );

    pst_seq #(
        .DMA_AW    (DMA_AW),
        .DW        (DW),
        .PAGE_LSB  (PST_PAGE_LSB),
        .PFN_SHIFT (PST_PFN_SHIFT)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tr_valid      (tr_valid),
        .tr_ready      (tr_ready),
        .tr_off        (tr_addr[PST_PAGE_LSB-1:0]),
        .m_hit         (m_hit),
        .m_sg          (m_sg),
        .m_pte         (m_pte),
        .m_direct      (m_direct),
        .res_valid     (res_valid),
        .res_ready     (res_ready),
        .res_addr      (res_addr),
        .res_miss      (res_miss),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

endmodule

// File: tb/pci_sg_translator_tb_top.sv
`timescale 1ns/1ps
module pci_sg_translator_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_req = 1'b0, csr_we = 1'b0;
    logic [3:0]  csr_idx = '0;
    logic [1:0]  csr_size = '0;
    logic [63:0] csr_wdata = '0;
    logic        csr_ack, csr_rej;
    logic [63:0] csr_rdata;
    logic        tr_valid = 1'b0;
    logic        tr_ready;
    logic [31:0] tr_addr = '0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [33:0] res_addr;
    logic        res_miss;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int errors = 0;
    int checks = 0;
    int mem_reads = 0;
    int mem_stall = 0;
    int mem_lat = 1;
    logic [33:0] last_pte = '0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pci_sg_translator dut_i (
        .clk (clk), .rst_n (rst_n),
        .csr_req (csr_req), .csr_we (csr_we), .csr_idx (csr_idx),
        .csr_size (csr_size), .csr_wdata (csr_wdata),
        .csr_ack (csr_ack), .csr_rej (csr_rej), .csr_rdata (csr_rdata),
        .tr_valid (tr_valid), .tr_ready (tr_ready), .tr_addr (tr_addr),
        .res_valid (res_valid), .res_ready (res_ready),
        .res_addr (res_addr), .res_miss (res_miss),
        .mem_req_valid (mem_req_valid), .mem_req_ready (mem_req_ready),
        .mem_req_addr (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_data (mem_rsp_data)
    );

    function automatic logic [63:0] mem_word(input logic [33:0] a);
        return ({30'b0, a} >> 3) | 64'h1;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Memory model: stalls the request, then answers after a latency.
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                repeat (mem_stall) @(negedge clk);
                mem_req_ready = 1'b1;
                last_pte = mem_req_addr;
                @(negedge clk);
                mem_req_ready = 1'b0;
                mem_reads++;
                repeat (mem_lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data = mem_word(last_pte);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
            end
        end
    end

    task automatic csr_op(input logic we, input logic [3:0] idx, input logic [1:0] sz,
                          input logic [63:0] wd, output logic [63:0] rd, output logic rj);
        @(negedge clk);
        csr_req = 1'b1; csr_we = we; csr_idx = idx; csr_size = sz; csr_wdata = wd;
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0;
        rd = csr_rdata;
        rj = csr_rej;
    endtask

    task automatic csr_wr(input logic [3:0] idx, input logic [63:0] wd);
        logic [63:0] rd;
        logic rj;
        csr_op(1'b1, idx, 2'd3, wd, rd, rj);
    endtask

    task automatic csr_rd(input logic [3:0] idx, output logic [63:0] rd);
        logic rj;
        csr_op(1'b0, idx, 2'd3, '0, rd, rj);
    endtask

    task automatic xlate(input logic [31:0] bus, input int hold,
                         output logic [33:0] a, output logic m, output int reads);
        int r0;
        logic [33:0] a0;
        r0 = mem_reads;
        @(negedge clk);
        tr_valid = 1'b1; tr_addr = bus;
        while (!tr_ready) @(negedge clk);
        @(negedge clk);
        tr_valid = 1'b0;
        while (!res_valid) @(negedge clk);
        a0 = res_addr;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R11 held valid", {63'b0, res_valid}, 64'd1);
            check("R11 held addr", {30'b0, res_addr}, {30'b0, a0});
            check("R11 ready low while held", {63'b0, tr_ready}, 64'd0);
        end
        a = res_addr;
        m = res_miss;
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        reads = mem_reads - r0;
    endtask

    typedef struct packed {
        logic [31:0] bus;
        logic [33:0] addr;
        logic        miss;
        logic        sg;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'h0012_3456, 34'h2_0002_3456, 1'b0, 1'b0},  // R6 R9 direct, high tba bits cut
        '{32'h001F_FFFF, 34'h2_000F_FFFF, 1'b0, 1'b0},  // R6 window top edge
        '{32'h4567_8ABC, 34'h2_82B3_CABC, 1'b0, 1'b1},  // R7 R8 R9 scatter-gather
        '{32'h8123_4567, 34'h0_4123_4567, 1'b0, 1'b0},  // R5 overlap, lower window wins
        '{32'hC000_0010, 34'h0_2000_0010, 1'b0, 1'b1},  // R7 R8 upper window only
        '{32'h2000_0000, 34'h0,           1'b1, 1'b0},  // R10 miss
        '{32'hFFFF_FFFF, 34'h0_3FFF_FFFF, 1'b0, 1'b1},  // R8 all-ones offset
        '{32'h4000_0000, 34'h2_8000_0000, 1'b0, 1'b1},  // R8 zero offset
        '{32'h0020_0000, 34'h0,           1'b1, 1'b0}   // R10 just past window 0
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic rj;
        logic [33:0] a;
        logic m;
        int reads;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        check("R2 tr_ready", {63'b0, tr_ready}, 64'd1);
        check("R2 res_valid", {63'b0, res_valid}, 64'd0);
        check("R2 mem_req_valid", {63'b0, mem_req_valid}, 64'd0);
        csr_rd(4'd12, rd);
        check("R2 control reset", rd, 64'h0000_0021_0010_0000);
        csr_rd(4'd1, rd);
        check("R2 base reset", rd, 64'h0);
        csr_rd(4'd9, rd);
        check("R2 xlat base reset", rd, 64'h0);

        // R1 program windows
        csr_wr(4'd0, 64'h0010_0001);  csr_wr(4'd4, 64'h0);
        csr_wr(4'd8, 64'h0000_00F2_0000_0000);
        csr_wr(4'd1, 64'h4000_0003);  csr_wr(4'd5, 64'h0FF0_0000);
        csr_wr(4'd9, 64'h1_2340_0000);
        csr_wr(4'd2, 64'h8000_0001);  csr_wr(4'd6, 64'h3FF0_0000);
        csr_wr(4'd10, 64'h4000_0000);
        csr_wr(4'd3, 64'h8000_0003);  csr_wr(4'd7, 64'h7FF0_0000);
        csr_wr(4'd11, 64'h3_0000_0000);
        csr_rd(4'd8, rd);
        check("R1 readback xlat base 0", rd, 64'h0000_00F2_0000_0000);
        csr_rd(4'd7, rd);
        check("R1 readback mask 3", rd, 64'h7FF0_0000);
        csr_wr(4'd12, 64'hDEAD_BEEF_0123_4567);
        csr_rd(4'd12, rd);
        check("R1 control readback", rd, 64'hDEAD_BEEF_0123_4567);

        // R3 fixed-zero registers
        for (int i = 13; i < 16; i++) begin
            csr_wr(4'(i), 64'hFFFF_FFFF_FFFF_FFFF);
            csr_rd(4'(i), rd);
            check("R3 reads zero", rd, 64'h0);
        end
        csr_rd(4'd0, rd);
        check("R3 write to fixed regs leaves base 0", rd, 64'h0010_0001);

        // R4 size rejection
        csr_op(1'b1, 4'd2, 2'd2, 64'h0, rd, rj);
        check("R4 reject flag on size 2", {63'b0, rj}, 64'd1);
        csr_rd(4'd2, rd);
        check("R4 rejected write did not store", rd, 64'h8000_0001);
        csr_op(1'b0, 4'd2, 2'd0, 64'h0, rd, rj);
        check("R4 reject flag on size 0", {63'b0, rj}, 64'd1);
        check("R4 rejected read data zero", rd, 64'h0);

        // Table walk: R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 9; i++) begin
            mem_stall = i % 3;
            mem_lat = (i % 2) + 1;
            xlate(VECS[i].bus, 0, a, m, reads);
            check($sformatf("R6/R8 vec %0d address", i), {30'b0, a}, {30'b0, VECS[i].addr});
            check($sformatf("R10 vec %0d miss", i), {63'b0, m}, {63'b0, VECS[i].miss});
            check($sformatf("R7 vec %0d memory reads", i), 64'(reads), VECS[i].sg ? 64'd1 : 64'd0);
        end

        // R7 entry address of the first scatter-gather vector
        xlate(32'h4567_8ABC, 0, a, m, reads);
        check("R7 entry address", {30'b0, last_pte}, 64'h1_2341_59E0);

        // R11 backpressure on a scatter-gather result
        mem_stall = 2; mem_lat = 3;
        xlate(32'h4567_8ABC, 5, a, m, reads);
        check("R11 result after hold", {30'b0, a}, 64'h2_82B3_CABC);

        // R3 invalidate-all write does not disturb a translation
        csr_wr(4'd15, 64'h1);
        xlate(32'h8123_4567, 0, a, m, reads);
        check("R3 result unchanged after invalidate write", {30'b0, a}, 64'h0_4123_4567);

        // R5 disabled windows never match
        csr_wr(4'd0, 64'h0010_0000);
        xlate(32'h0012_3456, 0, a, m, reads);
        check("R5 disabled window gives miss", {63'b0, m}, 64'd1);
        check("R10 miss makes no read", 64'(reads), 64'd0);
        csr_wr(4'd2, 64'h8000_0000);
        xlate(32'hC000_0010, 0, a, m, reads);
        check("R5 upper window after lower disabled", {30'b0, a}, 64'h0_2000_0010);
        xlate(32'h8123_4567, 0, a, m, reads);
        check("R5 overlap now routed to window 3", {63'b0, m}, 64'd0);
        check("R7 overlap now reads memory once", 64'(reads), 64'd1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule